// File: doc/BRIEF.md
# Serial EEPROM Bit-Level Port with Memory-Port Arbitration

This block lets software drive an external three-wire serial EEPROM one bit at a time through a single 8-bit control register. The EEPROM shares its pins with a memory port that other users also need. Setting the request bit therefore starts an arbitration. The EEPROM pins carry the register's select, clock and data bits only after the port has been granted. Software generates the whole EEPROM command protocol by writing the register repeatedly and reading the returned serial data bit.

The ready bit has two jobs. On the first request it marks that the port has been granted, and that grant carries no timing. While the port is held, every further register write clears the ready bit. The bit then rises again after a fixed settling time of about 800 ns, counted in system clocks. Software can use this as its bit-period timer. Clearing the request bit releases the port at once.

Top module: `eeprom_bitport`

## Requirements
- R1: After reset, the readback value is 0x00, all three EEPROM pins are low and no port grant is given.
- R2: Register layout. Bit 5 is the request, bit 4 is the ready flag (read-only), bit 3 is the chip select, bit 2 is the serial clock, bit 1 is the data driven to the EEPROM, and bit 0 is the data read from the EEPROM (read-only). The written request bit reads back from the cycle after the write.
- R3: With the port idle, a write that sets the request bit gives the grant one cycle later. The ready bit reads 1 from the second cycle after the write, with no settling delay.
- R4: The port grant goes to at most one user at a time. When several users request an idle port in the same cycle, the other users win over the EEPROM, and among them the lowest index wins.
- R5: A user keeps the port as long as its request stays high. After its request drops, the port spends one cycle idle before the next grant.
- R6: While the EEPROM does not hold the port, the select, clock and data pins stay low and the ready bit reads 0, whatever the register holds.
- R7: While the port is held, register bits 3, 2 and 1 drive the select, clock and data pins from the cycle after the write.
- R8: While the port is held, bit 0 returns the EEPROM data output as sampled one clock earlier. Otherwise bit 0 reads 0.
- R9: Any register write while the port is held clears the ready bit for exactly SETTLE_CYC = ceil(SETTLE_NS*1000/CLK_PERIOD_PS) cycles after the write edge.
- R10: A write with bit 5 clear releases the port. From the next cycle, the ready bit and all pins read 0, and another user can be granted afterwards.
- R11: Written values of bits 7, 6, 4 and 0 have no effect, and bits 7 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register readback |
| other_req | input | NUM_OTHERS | Port requests from the other port users |
| other_gnt | output | NUM_OTHERS | Port grants to the other port users |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |

## Verification
The bench builds the block with NUM_OTHERS = 2 and CLK_PERIOD_PS = 20000, which matches its 50 MHz clock. With these values the settling window is 40 cycles, so the bench can measure the exact length of the ready-low period against the real 800 ns. Having two competing users lets it check that a lower-index user beats the EEPROM for an idle port, and that one user holds the port while the EEPROM waits with its pins low. It also checks the idle cycle between a release and the next grant.

// File: rtl/eeprom_bitport_pkg.sv
package eeprom_bitport_pkg;

    localparam int REG_W   = 8;
    localparam int BIT_REQ = 5;
    localparam int BIT_RDY = 4;
    localparam int BIT_CS  = 3;
    localparam int BIT_SK  = 2;
    localparam int BIT_DO  = 1;
    localparam int BIT_DI  = 0;

    typedef struct packed {
        logic req;
        logic cs;
        logic sk;
        logic dout;
    } ctl_t;

    typedef struct packed {
        logic ready;
        logic din;
    } stat_t;

    function automatic int settle_cycles(input int ns, input int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic ctl_t decode_write(input logic [REG_W-1:0] d);
        ctl_t c;
        c.req  = d[BIT_REQ];
        c.cs   = d[BIT_CS];
        c.sk   = d[BIT_SK];
        c.dout = d[BIT_DO];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] encode_read(input ctl_t c, input stat_t s);
        logic [REG_W-1:0] r;
        r          = '0;
        r[BIT_REQ] = c.req;
        r[BIT_RDY] = s.ready;
        r[BIT_CS]  = c.cs;
        r[BIT_SK]  = c.sk;
        r[BIT_DO]  = c.dout;
        r[BIT_DI]  = s.din;
        return r;
    endfunction

endpackage

// File: rtl/eeprom_port_arbiter.sv
module eeprom_port_arbiter #(
    parameter int NUM_USERS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_USERS-1:0] req,
    output logic [NUM_USERS-1:0] gnt
);

    logic [NUM_USERS-1:0] pick;
    logic [NUM_USERS-1:0] gnt_next;

    always_comb begin
        pick = '0;
        for (int i = NUM_USERS - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    always_comb begin
        if (|(gnt & req)) begin
            gnt_next = gnt;
        end else if (gnt == '0) begin
            gnt_next = pick;
        end else begin
            gnt_next = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt <= '0;
        end else begin
            gnt <= gnt_next;
        end
    end

endmodule

// File: rtl/eeprom_settle_timer.sv
module eeprom_settle_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic restart,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/eeprom_bitport.sv
module eeprom_bitport
    import eeprom_bitport_pkg::*;
#(
    parameter int NUM_OTHERS    = 2,
    parameter int CLK_PERIOD_PS = 20000,
    parameter int SETTLE_NS     = 800
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic [NUM_OTHERS-1:0] other_req,
    output logic [NUM_OTHERS-1:0] other_gnt,
    output logic                  ee_cs,
    output logic                  ee_sk,
    output logic                  ee_di,
    input  logic                  ee_do
);

    localparam int SETTLE_CYC = settle_cycles(SETTLE_NS, CLK_PERIOD_PS);
    localparam int NUM_USERS  = NUM_OTHERS + 1;
    localparam int EE_IDX     = NUM_OTHERS;

    ctl_t                 ctl_q;
    logic                 din_q;
    logic [NUM_USERS-1:0] all_req;
    logic [NUM_USERS-1:0] all_gnt;
    logic                 ee_gnt;
    logic                 ee_req_q;
    logic                 ee_own;
    logic                 settled;
    stat_t                stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            din_q <= 1'b0;
        end else begin
            din_q <= ee_do;
            if (reg_wr) begin
                ctl_q <= decode_write(reg_wdata);
            end
        end
    end

    assign ee_req_q = ctl_q.req;
    assign all_req  = {ee_req_q, other_req};

    eeprom_port_arbiter #(
        .NUM_USERS(NUM_USERS)
    ) u_arb (
        .clk (clk),
        .rst (rst),
        .req (all_req),
        .gnt (all_gnt)
    );

    assign ee_gnt    = all_gnt[EE_IDX];
    assign other_gnt = all_gnt[NUM_OTHERS-1:0];
    assign ee_own    = ee_gnt & ee_req_q;

    eeprom_settle_timer #(
        .CYCLES(SETTLE_CYC)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .enable  (ee_gnt),
        .restart (reg_wr & ee_gnt),
        .done    (settled)
    );

    assign stat.ready = ee_own & settled;
    assign stat.din   = ee_own & din_q;

    assign ee_cs = ee_own & ctl_q.cs;
    assign ee_sk = ee_own & ctl_q.sk;
    assign ee_di = ee_own & ctl_q.dout;

    assign reg_rdata = encode_read(ctl_q, stat);

endmodule

// File: rtl/eeprom_bitport_chk.sv
module eeprom_bitport_chk #(
    parameter int NUM_OTHERS = 2,
    parameter int SETTLE_CYC = 40
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_wr,
    input logic [7:0]            reg_wdata,
    input logic [7:0]            reg_rdata,
    input logic [NUM_OTHERS-1:0] other_req,
    input logic [NUM_OTHERS-1:0] other_gnt,
    input logic                  ee_cs,
    input logic                  ee_sk,
    input logic                  ee_di,
    input logic                  ee_gnt,
    input logic                  ee_req_q
);

    localparam int CW = $clog2(SETTLE_CYC + 2);

    logic [CW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || !(ee_gnt && ee_req_q) || reg_rdata[4]) begin
            low_run <= '0;
        end else if (low_run <= CW'(SETTLE_CYC)) begin
            low_run <= low_run + 1'b1;
        end
    end

    assert_single_grant_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ee_gnt, other_gnt}));

    assert_pins_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !ee_gnt |-> (!ee_cs && !ee_sk && !ee_di && !reg_rdata[4]));

    assert_settle_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[5] && ee_gnt && ee_req_q) |=> !reg_rdata[4]);

    assert_settle_bound_R9: assert property (@(posedge clk) disable iff (rst)
        low_run <= CW'(SETTLE_CYC));

    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[5]) |=> (!reg_rdata[4] && !ee_cs && !ee_sk && !ee_di));

    assert_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7:6] == 2'b00);

    for (genvar i = 0; i < NUM_OTHERS; i++) begin : g_hold
        assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (other_gnt[i] && other_req[i]) |=> other_gnt[i]);
    end

endmodule

bind eeprom_bitport eeprom_bitport_chk #(
    .NUM_OTHERS(NUM_OTHERS),
    .SETTLE_CYC(SETTLE_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .other_req (other_req),
    .other_gnt (other_gnt),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di),
    .ee_gnt    (ee_gnt),
    .ee_req_q  (ee_req_q)
);

// File: tb/eeprom_bitport_tb.sv
module eeprom_bitport_tb;

    localparam int NUM_OTHERS = 2;
    localparam int PERIOD_PS  = 20000;
    localparam int EXP_SETTLE = (800 * 1000 + PERIOD_PS - 1) / PERIOD_PS;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  reg_wr = 1'b0;
    logic [7:0]            reg_wdata = 8'h00;
    logic [7:0]            reg_rdata;
    logic [NUM_OTHERS-1:0] other_req = '0;
    logic [NUM_OTHERS-1:0] other_gnt;
    logic                  ee_cs, ee_sk, ee_di;
    logic                  ee_do = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10ns clk = ~clk;

    eeprom_bitport #(
        .NUM_OTHERS(NUM_OTHERS),
        .CLK_PERIOD_PS(PERIOD_PS),
        .SETTLE_NS(800)
    ) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .other_req(other_req), .other_gnt(other_gnt),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic pins(input string req, input logic [2:0] exp);
        check(req, {ee_cs, ee_sk, ee_di}, exp);
    endtask

    task automatic t_reset;
        check("R1 rdata", reg_rdata, 8'h00);
        pins("R1 pins", 3'b000);
        check("R1 grants", other_gnt, 0);
    endtask

    task automatic t_first_grant;
        write_reg(8'h20);
        check("R2 req readback", reg_rdata[5], 1);
        check("R3 ready not yet", reg_rdata[4], 0);
        @(negedge clk);
        check("R3 ready on grant", reg_rdata[4], 1);
    endtask

    task automatic t_drive_and_settle;
        int waited;
        write_reg(8'h2E);
        pins("R7 pins follow bits", 3'b111);
        check("R9 ready cleared", reg_rdata[4], 0);
        waited = 0;
        while (reg_rdata[4] == 1'b0 && waited < 1000) begin
            @(negedge clk);
            waited++;
        end
        check("R9 settle length", waited, EXP_SETTLE);
        write_reg(8'h24);
        pins("R7 clock only", 3'b010);
    endtask

    task automatic t_data_in;
        ee_do = 1'b1;
        @(negedge clk);
        check("R8 din high", reg_rdata[0], 1);
        ee_do = 1'b0;
        @(negedge clk);
        check("R8 din low", reg_rdata[0], 0);
        ee_do = 1'b1;
    endtask

    task automatic t_ignored_bits;
        write_reg(8'hF1);
        check("R11 upper bits", reg_rdata[7:6], 0);
        check("R11 ready not writable", reg_rdata[4], 0);
        pins("R11 pins", 3'b000);
        check("R11 din follows pin", reg_rdata[0], 1);
        ee_do = 1'b0;
    endtask

    task automatic t_release;
        write_reg(8'h0E);
        check("R10 ready dropped", reg_rdata[4], 0);
        pins("R10 pins dropped", 3'b000);
        check("R10 din gated", reg_rdata[0], 0);
        other_req = 2'b10;
        @(negedge clk);
        check("R10 port idle", other_gnt, 2'b00);
        @(negedge clk);
        check("R10 other granted", other_gnt, 2'b10);
    endtask

    task automatic t_contention;
        write_reg(8'h2E);
        repeat (3) @(negedge clk);
        pins("R6 pins held low", 3'b000);
        check("R6 ready low", reg_rdata[4], 0);
        check("R5 holder kept", other_gnt, 2'b10);
        other_req = 2'b01;
        @(negedge clk);
        check("R5 idle gap", other_gnt, 2'b00);
        @(negedge clk);
        check("R4 other beats eeprom", other_gnt, 2'b01);
        pins("R6 still low", 3'b000);
        other_req = 2'b00;
        @(negedge clk);
        check("R5 idle before eeprom", reg_rdata[4], 0);
        @(negedge clk);
        check("R3 late grant ready", reg_rdata[4], 1);
        pins("R7 pins after late grant", 3'b111);
        check("R4 no other grant", other_gnt, 2'b00);
    endtask

    task automatic t_priority_among_others;
        write_reg(8'h00);
        @(negedge clk);
        other_req = 2'b11;
        @(negedge clk);
        check("R4 lowest index", other_gnt, 2'b01);
        other_req = 2'b00;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_grant();
        t_drive_and_settle();
        t_data_in();
        t_ignored_bits();
        t_release();
        t_contention();
        t_priority_among_others();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule